// File: doc/BRIEF.md
# Random Excluding Tag Generator

This block picks a 4-bit allocation tag for a 64-bit pointer. A 16-bit linear feedback shift register produces a pseudo-random 4-bit offset. The block then walks through the sixteen possible tag values, starting at the tag left by the previous request and skipping every value that is excluded, until the offset has been used up. The result is written into bits [59:56] of the pointer. The new seed and the chosen tag are kept in a state register, and the next request starts from them.

A request is one cycle of `req` while the block is idle. The block first steps the shift register four times, one step per clock. It then moves the tag by at most one increment per clock. It finishes with a one-cycle `done` pulse, and on that pulse the new pointer and state can be read. The state register can be loaded from outside while the block is idle. A zero seed with random mode set is replaced by 16'h0001.

Top module: `rand_tag_gen`

## Requirements
- R1: The exclusion mask used for a request is the bitwise OR of `excl_op` and `ctl_excl`. When bit k of that mask is set, tag k is never produced, unless every bit is set.
- R2: One shift-register step computes feedback = seed[5]^seed[3]^seed[2]^seed[0] and then sets seed = {feedback, seed[15:1]}. Each request takes exactly four steps. The feedback of step i (i = 0..3) becomes bit i of the offset. The seed after the fourth step appears in `state_out[23:8]` once `done` is high.
- R3: If all 16 mask bits are set, the result tag is 0.
- R4: If the offset is 0, the result is the first non-excluded tag found counting up from the start tag, with the start tag included and wrapping modulo 16.
- R5: If the offset is non-zero, the tag is advanced offset times. Each advance adds 1 modulo 16 at least once and keeps adding past excluded values.
- R6: `state_out` holds the tag in [3:0] and the seed in [23:8], with bits [7:4] reading 0. The start tag of a request is `state_out[3:0]`. When `state_wr` is high while the block is idle, `state_out` is loaded from `state_wdata` (bits [7:4] are dropped). Otherwise `state_out` changes only when `done` is high.
- R7: If the seed is zero and `ctl_rand` is 1, the seed 16'h0001 is used before the shift register is stepped. If `ctl_rand` is 0, a zero seed stays zero and the offset is 0.
- R8: On `done`, `ptr_out` equals the accepted pointer with bits [59:56] replaced by the result tag. All other bits are unchanged.
- R9: `done` is high for exactly one cycle per accepted request. A `req` that arrives while a request is in progress is ignored.
- R10: After reset, `done` is 0, `ptr_out` is 0 and `state_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, taken only while idle |
| ptr_in | input | 64 | Pointer to be tagged |
| excl_op | input | 16 | Exclusion operand for this request |
| ctl_excl | input | 16 | Global exclusion mask |
| ctl_rand | input | 1 | Random mode; enables substitution of a zero seed |
| state_wr | input | 1 | Load strobe for the state register |
| state_wdata | input | 24 | Value to load: tag [3:0], seed [23:8] |
| done | output | 1 | One-cycle completion pulse |
| ptr_out | output | 64 | Pointer with the new tag |
| state_out | output | 24 | State register: tag [3:0], seed [23:8] |

## Verification
The offset-zero path is the hardest case to reach, because the offset comes from four feedback bits of the seed and most seeds give a non-zero value. To reach it, the bench searches the seed space with its own model for a seed whose four feedback bits are all zero. It loads that seed through the state port together with an excluded start tag, so the inclusive upward search has to skip past values. The zero-seed case only occurs when zero is loaded, so the bench does that twice, once with random mode set and once with it clear.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LFSR = 2'd1,
    ST_WALK = 2'd2,
    ST_FIN  = 2'd3
  } rtg_state_e;
endpackage

// File: rtl/rtg_lfsr_step.sv
module rtg_lfsr_step #(
  parameter int SEED_W = 16
) (
  input  logic [SEED_W-1:0] seed,
  output logic [SEED_W-1:0] seed_nxt,
  output logic              fb
);
  always_comb begin
    fb       = seed[5] ^ seed[3] ^ seed[2] ^ seed[0];
    seed_nxt = {fb, seed[SEED_W-1:1]};
  end
endmodule

// File: rtl/rtg_seed_sel.sv
module rtg_seed_sel #(
  parameter int          SEED_W   = 16,
  parameter logic [15:0] SEED_SUB = 16'h0001
) (
  input  logic [SEED_W-1:0] seed,
  input  logic              rand_mode,
  output logic [SEED_W-1:0] seed_use
);
  always_comb begin
    if ((seed == '0) && rand_mode) seed_use = SEED_W'(SEED_SUB);
    else                           seed_use = seed;
  end
endmodule

// File: rtl/rtg_walk_step.sv
module rtg_walk_step #(
  parameter int TAG_W = 4,
  localparam int NTAG = 1 << TAG_W
) (
  input  logic [TAG_W-1:0] tag,
  input  logic [TAG_W-1:0] remain,
  input  logic [NTAG-1:0]  mask,
  output logic [TAG_W-1:0] tag_nxt,
  output logic [TAG_W-1:0] remain_nxt,
  output logic             finish,
  output logic [TAG_W-1:0] result
);
  logic all_excl;
  logic inc_ok;

  always_comb begin
    all_excl   = &mask;
    tag_nxt    = tag + TAG_W'(1);
    inc_ok     = !mask[tag_nxt];
    finish     = all_excl || ((remain == '0) && !mask[tag]);
    result     = all_excl ? '0 : tag;
    remain_nxt = ((remain != '0) && inc_ok) ? remain - TAG_W'(1) : remain;
  end
endmodule

// File: rtl/rand_tag_gen.sv
module rand_tag_gen #(
  parameter int          PTR_W    = 64,
  parameter int          TAG_W    = 4,
  parameter int          TAG_LSB  = 56,
  parameter int          SEED_W   = 16,
  parameter int          SEED_LSB = 8,
  parameter logic [15:0] SEED_SUB = 16'h0001,
  localparam int NTAG    = 1 << TAG_W,
  localparam int STATE_W = SEED_LSB + SEED_W,
  localparam int CNT_W   = (TAG_W > 1) ? $clog2(TAG_W) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [PTR_W-1:0]   ptr_in,
  input  logic [NTAG-1:0]    excl_op,
  input  logic [NTAG-1:0]    ctl_excl,
  input  logic               ctl_rand,
  input  logic               state_wr,
  input  logic [STATE_W-1:0] state_wdata,
  output logic               done,
  output logic [PTR_W-1:0]   ptr_out,
  output logic [STATE_W-1:0] state_out
);
  import rtg_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rtg_state_e         st_q, st_d;
  logic [SEED_W-1:0]  seed_q, seed_d;
  logic [TAG_W-1:0]   tag_q, tag_d;
  logic [TAG_W-1:0]   remain_q, remain_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [NTAG-1:0]    mask_q, mask_d;
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic [TAG_W-1:0]   s_tag_q, s_tag_d;
  logic [SEED_W-1:0]  s_seed_q, s_seed_d;
  logic [PTR_W-1:0]   pout_q, pout_d;
  logic               done_q, done_d;

  logic [SEED_W-1:0]  seed_use;
  logic [SEED_W-1:0]  lfsr_nxt;
  logic               lfsr_fb;
  logic [TAG_W-1:0]   w_tag_nxt, w_remain_nxt, w_result;
  logic               w_finish;
  logic [TAG_W-1:0]   ofs_acc;
  logic [PTR_W-1:0]   ptr_merged;

  rtg_seed_sel #(.SEED_W(SEED_W), .SEED_SUB(SEED_SUB)) u_seed_sel (
    .seed      (s_seed_q),
    .rand_mode (ctl_rand),
    .seed_use  (seed_use)
  );

  rtg_lfsr_step #(.SEED_W(SEED_W)) u_lfsr (
    .seed     (seed_q),
    .seed_nxt (lfsr_nxt),
    .fb       (lfsr_fb)
  );

  rtg_walk_step #(.TAG_W(TAG_W)) u_walk (
    .tag        (tag_q),
    .remain     (remain_q),
    .mask       (mask_q),
    .tag_nxt    (w_tag_nxt),
    .remain_nxt (w_remain_nxt),
    .finish     (w_finish),
    .result     (w_result)
  );

  // pointer with its tag field replaced
  always_comb begin
    ptr_merged                      = ptr_q;
    ptr_merged[TAG_LSB +: TAG_W]    = w_result;
  end

  always_comb begin
    ofs_acc = remain_q | (TAG_W'(lfsr_fb) << cnt_q);
  end

  // next-state logic
  always_comb begin
    st_d     = st_q;
    seed_d   = seed_q;
    tag_d    = tag_q;
    remain_d = remain_q;
    cnt_d    = cnt_q;
    mask_d   = mask_q;
    ptr_d    = ptr_q;
    s_tag_d  = s_tag_q;
    s_seed_d = s_seed_q;
    pout_d   = pout_q;
    done_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (state_wr) begin
          s_tag_d  = state_wdata[TAG_W-1:0];
          s_seed_d = state_wdata[SEED_LSB +: SEED_W];
        end else if (req) begin
          ptr_d    = ptr_in;
          mask_d   = excl_op | ctl_excl;
          seed_d   = seed_use;
          tag_d    = s_tag_q;
          remain_d = '0;
          cnt_d    = '0;
          st_d     = ST_LFSR;
        end
      end
      ST_LFSR: begin
        seed_d   = lfsr_nxt;
        remain_d = ofs_acc;
        cnt_d    = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(TAG_W - 1)) st_d = ST_WALK;
      end
      ST_WALK: begin
        if (w_finish) begin
          s_tag_d  = w_result;
          s_seed_d = seed_q;
          pout_d   = ptr_merged;
          done_d   = 1'b1;
          st_d     = ST_FIN;
        end else begin
          tag_d    = w_tag_nxt;
          remain_d = w_remain_nxt;
        end
      end
      ST_FIN: begin
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q     <= ST_IDLE;
      seed_q   <= '0;
      tag_q    <= '0;
      remain_q <= '0;
      cnt_q    <= '0;
      mask_q   <= '0;
      ptr_q    <= '0;
      s_tag_q  <= '0;
      s_seed_q <= '0;
      pout_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      seed_q   <= seed_d;
      tag_q    <= tag_d;
      remain_q <= remain_d;
      cnt_q    <= cnt_d;
      mask_q   <= mask_d;
      ptr_q    <= ptr_d;
      s_tag_q  <= s_tag_d;
      s_seed_q <= s_seed_d;
      pout_q   <= pout_d;
      done_q   <= done_d;
    end
  end

  assign done      = done_q;
  assign ptr_out   = pout_q;
  assign state_out = {s_seed_q, {(SEED_LSB - TAG_W){1'b0}}, s_tag_q};
endmodule

// File: rtl/rand_tag_gen_chk.sv
module rand_tag_gen_chk #(
  parameter int PTR_W   = 64,
  parameter int TAG_LSB = 56,
  parameter int STATE_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req,
  input logic               state_wr,
  input logic [PTR_W-1:0]   ptr_in,
  input logic [15:0]        excl_op,
  input logic [15:0]        ctl_excl,
  input logic               done,
  input logic [PTR_W-1:0]   ptr_out,
  input logic [STATE_W-1:0] state_out
);
  logic             busy_c;
  logic [PTR_W-1:0] ptr_c;
  logic [15:0]      mask_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_c <= 1'b0;
      ptr_c  <= '0;
      mask_c <= '0;
    end else if (!busy_c) begin
      if (req && !state_wr) begin
        busy_c <= 1'b1;
        ptr_c  <= ptr_in;
        mask_c <= excl_op | ctl_excl;
      end
    end else if (done) begin
      busy_c <= 1'b0;
    end
  end

  // R9: completion lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: completion only for an accepted request
  a_r9_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy_c);

  // R8: only the tag field of the pointer changes
  a_r8_ptr_fields: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ptr_out[TAG_LSB-1:0] == ptr_c[TAG_LSB-1:0]) &&
             (ptr_out[PTR_W-1:TAG_LSB+4] == ptr_c[PTR_W-1:TAG_LSB+4]) &&
             (ptr_out[TAG_LSB +: 4] == state_out[3:0]));

  // R1: an excluded tag is never produced
  a_r1_not_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mask_c != 16'hffff)) |-> !mask_c[state_out[3:0]]);

  // R3: full mask gives tag 0
  a_r3_all_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mask_c == 16'hffff)) |-> (state_out[3:0] == 4'd0));

  // R6: state moves only on completion or load
  a_r6_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(state_wr)) |-> $stable(state_out));
endmodule

bind rand_tag_gen rand_tag_gen_chk #(
  .PTR_W(PTR_W), .TAG_LSB(TAG_LSB), .STATE_W(STATE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .state_wr  (state_wr),
  .ptr_in    (ptr_in),
  .excl_op   (excl_op),
  .ctl_excl  (ctl_excl),
  .done      (done),
  .ptr_out   (ptr_out),
  .state_out (state_out)
);

// File: tb/rand_tag_gen_bench.sv
module rand_tag_gen_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [63:0] ptr_in = '0;
  logic [15:0] excl_op = '0;
  logic [15:0] ctl_excl = '0;
  logic        ctl_rand = 1'b0;
  logic        state_wr = 1'b0;
  logic [23:0] state_wdata = '0;
  logic        done;
  logic [63:0] ptr_out;
  logic [23:0] state_out;

  int checks = 0;
  int fails = 0;
  logic [3:0]  m_tag = '0;
  logic [15:0] m_seed = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rand_tag_gen u_rand_tag_gen (
    .clk(clk), .rst_n(rst_n), .req(req), .ptr_in(ptr_in),
    .excl_op(excl_op), .ctl_excl(ctl_excl), .ctl_rand(ctl_rand),
    .state_wr(state_wr), .state_wdata(state_wdata),
    .done(done), .ptr_out(ptr_out), .state_out(state_out)
  );

  task automatic check(input string req_id, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_id, act, exp);
    end
  endtask

  function automatic logic [3:0] offset_of(input logic [15:0] s);
    logic [15:0] x = s;
    logic [3:0]  o = '0;
    for (int i = 0; i < 4; i++) begin
      logic f = x[5] ^ x[3] ^ x[2] ^ x[0];
      x = {f, x[15:1]};
      o[i] = f;
    end
    return o;
  endfunction

  function automatic logic [15:0] seed_after(input logic [15:0] s);
    logic [15:0] x = s;
    for (int i = 0; i < 4; i++) begin
      logic f = x[5] ^ x[3] ^ x[2] ^ x[0];
      x = {f, x[15:1]};
    end
    return x;
  endfunction

  function automatic logic [3:0] pick(input logic [3:0] start, input logic [3:0] ofs,
                                      input logic [15:0] mask);
    logic [3:0] t = start;
    if (mask == 16'hffff) return 4'd0;
    if (ofs == 0) begin
      while (mask[t]) t = t + 4'd1;
    end else begin
      for (int k = 0; k < ofs; k++) begin
        t = t + 4'd1;
        while (mask[t]) t = t + 4'd1;
      end
    end
    return t;
  endfunction

  task automatic load_state(input logic [3:0] tag, input logic [15:0] seed);
    @(negedge clk);
    state_wr = 1'b1;
    state_wdata = {seed, 4'hf, tag};
    @(negedge clk);
    state_wr = 1'b0;
    m_tag = tag;
    m_seed = seed;
    check("R6 load", {40'd0, state_out}, {40'd0, seed, 4'h0, tag});
  endtask

  // issue one request, compare with the model, check the pulse width
  task automatic run_req(input string req_id, input logic [63:0] p, input logic [15:0] op,
                         input logic [15:0] gm, input logic rnd, input bit extra_req);
    logic [15:0] s_use, mask;
    logic [3:0]  et;
    logic [63:0] ep;
    int wait_n = 0;
    s_use = (m_seed == 0 && rnd) ? 16'h0001 : m_seed;
    mask = op | gm;
    et = pick(m_tag, offset_of(s_use), mask);
    ep = p;
    ep[59:56] = et;
    @(negedge clk);
    ptr_in = p; excl_op = op; ctl_excl = gm; ctl_rand = rnd; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (extra_req) begin
      @(negedge clk);
      ptr_in = ~p; excl_op = 16'h0000; ctl_excl = 16'h0000; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    while (!done && wait_n < 400) begin
      @(negedge clk);
      wait_n++;
    end
    check({req_id, " done seen"}, {63'd0, done}, 64'd1);
    check({req_id, " R8 ptr"}, ptr_out, ep);
    check({req_id, " tag"}, {60'd0, state_out[3:0]}, {60'd0, et});
    check({req_id, " R2 seed"}, {48'd0, state_out[23:8]}, {48'd0, seed_after(s_use)});
    m_tag = et;
    m_seed = seed_after(s_use);
    @(negedge clk);
    check({req_id, " R9 pulse"}, {63'd0, done}, 64'd0);
  endtask

  task automatic t_reset;
    check("R10 done", {63'd0, done}, 64'd0);
    check("R10 ptr", ptr_out, 64'd0);
    check("R10 state", {40'd0, state_out}, 64'd0);
  endtask

  task automatic t_walk;
    load_state(4'd3, 16'hace1);
    run_req("R5 a", 64'h0123_4567_89ab_cdef, 16'h0000, 16'h0000, 1'b0, 0);
    run_req("R5 b", 64'hf0f0_0000_1111_2222, 16'h00f0, 16'h0000, 1'b0, 0);
    run_req("R1 split", 64'h8000_0000_0000_0001, 16'h5500, 16'h0055, 1'b0, 0);
    run_req("R6 chain", 64'h0fff_ffff_ffff_ffff, 16'h0001, 16'h8000, 1'b1, 0);
  endtask

  task automatic t_all_excl;
    load_state(4'd9, 16'h1234);
    run_req("R3 full", 64'hffff_ffff_ffff_ffff, 16'hff00, 16'h00ff, 1'b0, 0);
    check("R3 zero tag", {60'd0, ptr_out[59:56]}, 64'd0);
  endtask

  task automatic t_zero_offset;
    logic [15:0] s = 16'd1;
    while (offset_of(s) != 0) s = s + 16'd1;
    check("R4 search", {63'd0, offset_of(s) == 0}, 64'd1);
    load_state(4'd14, s);
    run_req("R4 wrap", 64'h0000_1000_0000_0040, 16'hc000, 16'h0000, 1'b0, 0);
    check("R4 first free", {60'd0, state_out[3:0]}, 64'd0);
  endtask

  task automatic t_zero_seed;
    load_state(4'd5, 16'h0000);
    run_req("R7 rand", 64'h1111_2222_3333_4444, 16'h0000, 16'h0000, 1'b1, 0);
    load_state(4'd6, 16'h0000);
    run_req("R7 norand", 64'h5555_6666_7777_8888, 16'h00c0, 16'h0000, 1'b0, 0);
    check("R7 seed stays 0", {48'd0, state_out[23:8]}, 64'd0);
  endtask

  task automatic t_busy;
    int extra = 0;
    load_state(4'd2, 16'hbeef);
    run_req("R9 busy", 64'h0a0b_0c0d_0e0f_1011, 16'h0a0a, 16'h0000, 1'b0, 1);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R9 no extra done", 64'(extra), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_walk();
    t_all_excl();
    t_zero_offset();
    t_zero_seed();
    t_busy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule